// File: doc/BRIEF.md
# Bitstream Header Lookup Parser

This block reads a configuration image header as a stream, one byte per valid beat, each beat tagged with its byte index. From the stream it works out two numbers. The first is how many leading bytes of the image must be skipped before the configuration data starts. The second is how many payload bytes follow. To find them it walks the header's table of block records, locates two particular blocks, and then sums a list of tightly packed component sizes.

Bytes arrive in increasing index order, and gaps in the index are allowed. The block never stores the whole image. It keeps a single pointer to the next byte it needs and takes the value only when that index appears. If the stream moves past a needed index, the block flags an error. A beat at index 0 begins a new image. A one-cycle `done` pulse marks a result as valid. `err` is a level that holds until the next image begins.

Top module: `hdr_lut_parser`

## Requirements
- R1: After reset, `done` and `err` are 0, and `skip_len` and `data_size` are 0.
- R2: The header length is the byte at index 24. A value below 26 raises `err`.
- R3: The record count is the byte at index (header length − 1). A count of zero raises `err`.
- R4: Records start at index (header length). Each record is 9 bytes: an ID byte, a 32-bit little-endian start offset in bytes 1 to 4, and four bytes that are ignored.
- R5: A record with ID 8 and a nonzero offset sets `skip_len` to that offset. A record with ID 5 and a nonzero offset sets the start of the size table. Once both have been seen, the remaining records are ignored.
- R6: If all records are used up before both IDs are seen, `err` is raised and `done` never pulses.
- R7: The component count is a little-endian 16-bit value at indices 55 and 56. Component i is the 22-bit field that starts at bit 22·i of the size table, where bit 0 is the least significant bit of the table's first byte. A field may span up to four bytes.
- R8: `data_size` equals 16 times the sum of all component sizes. `done` rises for exactly one cycle, in the cycle after the byte that completes the last component. With a count of zero, that byte is the one that completes the scan.
- R9: If the index jumps past a byte that is still needed, `err` is raised. If the size table starts at or before the byte that completed the scan, `err` is raised.
- R10: A valid beat at index 0 restarts parsing and clears `err`, `skip_len` and `data_size`.
- R11: `done` and `err` are never high together. `err` stays high until a restart. After `done`, later bytes do not change `skip_len` or `data_size`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Byte beat present |
| in_idx | input | 32 | Byte index within the image |
| in_byte | input | 8 | Byte value |
| skip_len | output | 32 | Header bytes to skip (bitstream start offset) |
| data_size | output | 42 | Payload byte count |
| done | output | 1 | One-cycle pulse: results are valid |
| err | output | 1 | Parse error, held until restart |

## Verification
The bench builds the block with its default parameters: 22-bit size fields, a 16-bit component count, a 16-byte frame and 9-byte records. Because 22 is not a multiple of 8, runs of up to 20 components place field starts at all four bit phases within a byte. A table row whose sizes are all at the maximum field value checks the width of the accumulator. Directed runs cover:
- index gaps;
- a size table that starts too early;
- a record set with a missing ID;
- record ID 8 entries that appear after the scan has stopped;
- restart behaviour;
- bytes sent after completion.

// File: rtl/hdr_lut_parser.sv
module hdr_lut_parser #(
  parameter int IDX_W       = 32,
  parameter int OFF_W       = 32,
  parameter int CNT_W       = 16,
  parameter int FIELD_W     = 22,
  parameter int FRAME_BYTES = 16,
  parameter int REC_BYTES   = 9,
  parameter int OFF_HLEN    = 24,
  parameter int OFF_NCOMP   = 55,
  parameter int MIN_HLEN    = 26,
  parameter logic [7:0] ID_STREAM = 8'd8,
  parameter logic [7:0] ID_SIZES  = 8'd5
) (
  input  logic                                          clk,
  input  logic                                          rst_n,
  input  logic                                          in_valid,
  input  logic [IDX_W-1:0]                              in_idx,
  input  logic [7:0]                                    in_byte,
  output logic [OFF_W-1:0]                              skip_len,
  output logic [CNT_W+FIELD_W+$clog2(FRAME_BYTES)-1:0]  data_size,
  output logic                                          done,
  output logic                                          err
);
  localparam int FSH       = $clog2(FRAME_BYTES);
  localparam int SUM_W     = CNT_W + FIELD_W;
  localparam int BUF_W     = FIELD_W + 8;
  localparam int BC_W      = $clog2(BUF_W + 1);
  localparam int OFF_BYTES = OFF_W / 8;
  localparam int RP_W      = $clog2(OFF_BYTES + 1);

  typedef enum logic [2:0] {S_LEN, S_NREC, S_REC, S_SIZE, S_END} st_t;

  st_t              state;
  logic [IDX_W-1:0] need;
  logic [7:0]       hlen, rec_left, rec_id;
  logic [RP_W-1:0]  rec_pos;
  logic [OFF_W-1:0] rec_val, bs_off, sz_off;
  logic             got_bs, got_sz, cnt_lo_ok, cnt_ok;
  logic [CNT_W-1:0] ncomp, nfield;
  logic [BUF_W-1:0] bitbuf;
  logic [BC_W-1:0]  bcnt;
  logic [SUM_W-1:0] sum;
  logic             done_q, err_q;

  wire restart = in_valid && (in_idx == '0);
  wire active  = (state != S_END);
  wire hit     = in_valid && active && (in_idx == need);
  wire miss    = in_valid && active && (in_idx > need);

  wire [OFF_W-1:0] full   = {in_byte, rec_val[OFF_W-1:8]};
  wire             is_bs  = (rec_id == ID_STREAM) && (full != '0);
  wire             is_sz  = (rec_id == ID_SIZES) && (full != '0);
  wire             nb_bs  = got_bs | is_bs;
  wire             nb_sz  = got_sz | is_sz;
  wire [OFF_W-1:0] new_sz = is_sz ? full : sz_off;

  wire [BUF_W-1:0] comb = bitbuf | (BUF_W'(in_byte) << bcnt);
  wire [BC_W-1:0]  c2   = bcnt + BC_W'(8);
  wire             emit = (c2 >= BC_W'(FIELD_W));

  assign skip_len  = bs_off;
  assign data_size = {sum, {FSH{1'b0}}};
  assign done      = done_q;
  assign err       = err_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= S_LEN;  need <= IDX_W'(OFF_HLEN);
      hlen <= '0;  rec_left <= '0;  rec_id <= '0;  rec_pos <= '0;  rec_val <= '0;
      bs_off <= '0;  sz_off <= '0;  got_bs <= 1'b0;  got_sz <= 1'b0;
      cnt_lo_ok <= 1'b0;  cnt_ok <= 1'b0;  ncomp <= '0;  nfield <= '0;
      bitbuf <= '0;  bcnt <= '0;  sum <= '0;  done_q <= 1'b0;  err_q <= 1'b0;
    end else if (restart) begin
      state <= S_LEN;  need <= IDX_W'(OFF_HLEN);
      rec_pos <= '0;  bs_off <= '0;  sz_off <= '0;  got_bs <= 1'b0;  got_sz <= 1'b0;
      cnt_lo_ok <= 1'b0;  cnt_ok <= 1'b0;  nfield <= '0;
      bitbuf <= '0;  bcnt <= '0;  sum <= '0;  done_q <= 1'b0;  err_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (in_valid && in_idx == IDX_W'(OFF_NCOMP)) begin
        ncomp[7:0] <= in_byte;
        cnt_lo_ok  <= 1'b1;
      end
      if (in_valid && in_idx == IDX_W'(OFF_NCOMP + 1)) begin
        ncomp[CNT_W-1:8] <= in_byte[CNT_W-9:0];
        cnt_ok           <= cnt_lo_ok;
      end
      if (miss) begin
        err_q <= 1'b1;
        state <= S_END;
      end else if (hit) begin
        case (state)
          S_LEN: begin
            hlen <= in_byte;
            if (in_byte < 8'(MIN_HLEN)) begin
              err_q <= 1'b1;  state <= S_END;
            end else begin
              need  <= IDX_W'(in_byte) - IDX_W'(1);
              state <= S_NREC;
            end
          end
          S_NREC: begin
            if (in_byte == '0) begin
              err_q <= 1'b1;  state <= S_END;
            end else begin
              rec_left <= in_byte;
              rec_pos  <= '0;
              need     <= IDX_W'(hlen);
              state    <= S_REC;
            end
          end
          S_REC: begin
            if (rec_pos == '0) begin
              rec_id  <= in_byte;
              rec_pos <= RP_W'(1);
              need    <= need + IDX_W'(1);
            end else if (rec_pos < RP_W'(OFF_BYTES)) begin
              rec_val <= full;
              rec_pos <= rec_pos + RP_W'(1);
              need    <= need + IDX_W'(1);
            end else begin
              if (is_bs) begin bs_off <= full;  got_bs <= 1'b1; end
              if (is_sz) begin sz_off <= full;  got_sz <= 1'b1; end
              rec_pos <= '0;
              if (nb_bs && nb_sz) begin
                if (IDX_W'(new_sz) <= in_idx) begin
                  err_q <= 1'b1;  state <= S_END;
                end else if (cnt_ok && ncomp == '0) begin
                  done_q <= 1'b1;  state <= S_END;
                end else begin
                  need  <= IDX_W'(new_sz);
                  state <= S_SIZE;
                end
              end else if (rec_left == 8'd1) begin
                err_q <= 1'b1;  state <= S_END;
              end else begin
                rec_left <= rec_left - 8'd1;
                need     <= need + IDX_W'(REC_BYTES - OFF_BYTES);
              end
            end
          end
          S_SIZE: begin
            if (!cnt_ok) begin
              err_q <= 1'b1;  state <= S_END;
            end else begin
              need <= need + IDX_W'(1);
              if (emit) begin
                sum    <= sum + SUM_W'(comb[FIELD_W-1:0]);
                bitbuf <= comb >> FIELD_W;
                bcnt   <= c2 - BC_W'(FIELD_W);
                nfield <= nfield + CNT_W'(1);
                if (nfield + CNT_W'(1) == ncomp) begin
                  done_q <= 1'b1;  state <= S_END;
                end
              end else begin
                bitbuf <= comb;
                bcnt   <= c2;
              end
            end
          end
          default: ;
        endcase
      end else if (state == S_SIZE && cnt_ok && nfield == ncomp) begin
        done_q <= 1'b1;
        state  <= S_END;
      end
    end
  end

  p_excl_r11: assert property (@(posedge clk) disable iff (!rst_n) !(done_q && err_q));
  p_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n) done_q |=> !done_q);
  p_err_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (err_q && !restart) |=> err_q);
  p_hold_after_done_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_END && !err_q && !restart) |=> ($stable(data_size) && $stable(skip_len)));
  p_buf_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_SIZE) |-> (bcnt < BC_W'(FIELD_W)));
  p_field_count_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_SIZE && cnt_ok) |-> (nfield <= ncomp));
  p_gap_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !restart && (state == S_LEN || state == S_NREC || state == S_REC) && in_idx > need)
    |=> err_q);
  p_restart_r10: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> (!err_q && !done_q && sum == '0));
endmodule

// File: tb/hdr_lut_parser_bench.sv
module hdr_lut_parser_bench;
  typedef struct packed {
    logic [7:0]  hlen;
    logic [7:0]  nrec;
    logic [7:0]  sbs;
    logic [7:0]  ssz;
    logic [31:0] bs;
    logic [15:0] sz;
    logic [15:0] nc;
    logic [7:0]  seed;
    logic        xerr;
  } row_t;

  localparam int NROWS = 10;
  localparam row_t ROWS [NROWS] = '{
    '{8'd71, 8'd2, 8'd0,   8'd1,   32'd1000,  16'd100, 16'd3,  8'd1, 1'b0},
    '{8'd71, 8'd4, 8'd3,   8'd1,   32'd4096,  16'd120, 16'd8,  8'd2, 1'b0},
    '{8'd80, 8'd5, 8'd2,   8'd0,   32'd333,   16'd140, 16'd5,  8'd3, 1'b0},
    '{8'd71, 8'd2, 8'd1,   8'd0,   32'd77,    16'd100, 16'd1,  8'd0, 1'b0},
    '{8'd71, 8'd2, 8'd0,   8'd1,   32'd500,   16'd100, 16'd0,  8'd4, 1'b0},
    '{8'd90, 8'd3, 8'd0,   8'd1,   32'd65536, 16'd200, 16'd20, 8'd7, 1'b0},
    '{8'd71, 8'd3, 8'd0,   8'hFF,  32'd900,   16'd120, 16'd2,  8'd5, 1'b1},
    '{8'd20, 8'd2, 8'd0,   8'd1,   32'd900,   16'd120, 16'd2,  8'd5, 1'b1},
    '{8'd71, 8'd0, 8'd0,   8'd1,   32'd900,   16'd120, 16'd2,  8'd5, 1'b1},
    '{8'd71, 8'd2, 8'd0,   8'd1,   32'd900,   16'd60,  16'd2,  8'd5, 1'b1}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [31:0] in_idx = '0;
  logic [7:0]  in_byte = '0;
  logic [31:0] skip_len;
  logic [41:0] data_size;
  logic        done, err;

  hdr_lut_parser u_hdr_lut_parser (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_idx(in_idx), .in_byte(in_byte),
    .skip_len(skip_len), .data_size(data_size), .done(done), .err(err));

  always #5 clk = ~clk;

  int n_chk = 0;
  int n_bad = 0;
  logic [7:0] img [0:511];
  int done_cnt, done_at, last_len;
  longint exp_ds;

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic logic [21:0] csize(input logic [7:0] seed, input int i);
    logic [31:0] h;
    if (seed == 8'd0) return 22'h3FFFFF;
    h = 32'(seed) * 32'h9E37 + 32'(i) * 32'h1F3D5 + 32'(i * i * 7);
    h = h ^ (h >> 9) ^ (32'(i) << 13);
    return h[21:0];
  endfunction

  task automatic build(input row_t r, output int len, output int lastb);
    int mx, base, bitpos;
    logic [21:0] v;
    logic [31:0] off;
    logic [7:0]  id;
    longint s;
    mx = -1;
    if (r.sbs != 8'hFF) mx = int'(r.sbs);
    if (r.ssz != 8'hFF && int'(r.ssz) > mx) mx = int'(r.ssz);
    for (int i = 0; i < 512; i++) img[i] = 8'((i * 37 + 11) & 255);
    for (int k = 0; k < int'(r.nrec); k++) begin
      base = int'(r.hlen) + 9 * k;
      if (k == int'(r.sbs)) begin id = 8'd8; off = r.bs; end
      else if (k == int'(r.ssz)) begin id = 8'd5; off = 32'(r.sz); end
      else if (k > mx) begin id = 8'd8; off = 32'd7777; end
      else begin id = 8'd3; off = 32'd4242; end
      img[base] = id;
      for (int b = 0; b < 4; b++) img[base + 1 + b] = off[8*b +: 8];
    end
    s = 0;
    for (int i = 0; i < int'(r.nc); i++) begin
      v = csize(r.seed, i);
      s += longint'(v);
      for (int b = 0; b < 22; b++) begin
        bitpos = int'(r.sz) * 8 + i * 22 + b;
        img[bitpos / 8][bitpos % 8] = v[b];
      end
    end
    exp_ds = s * 16;
    img[24] = r.hlen;
    img[55] = r.nc[7:0];
    img[56] = r.nc[15:8];
    if (r.hlen != 0) img[int'(r.hlen) - 1] = r.nrec;
    if (r.nc != 0) lastb = int'(r.sz) + (int'(r.nc) * 22 - 1) / 8;
    else lastb = int'(r.hlen) + 9 * mx + 4;
    len = int'(r.sz) + (int'(r.nc) * 22 + 7) / 8;
    if (int'(r.hlen) + 9 * int'(r.nrec) > len) len = int'(r.hlen) + 9 * int'(r.nrec);
    len += 4;
  endtask

  task automatic stream(input int len, input int skip_idx);
    done_cnt = 0; done_at = -1;
    for (int idx = 0; idx < len; idx++) begin
      @(negedge clk);
      if (done) begin done_cnt++; done_at = idx - 1; end
      in_valid = (idx != skip_idx);
      in_idx   = 32'(idx);
      in_byte  = img[idx];
    end
    @(negedge clk);
    if (done) begin done_cnt++; done_at = len - 1; end
    in_valid = 1'b0;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      if (done) done_cnt++;
    end
  endtask

  initial begin
    #1_000_000;
    n_bad++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk + 1, n_bad);
    $finish;
  end

  initial begin
    int len, lastb;
    repeat (3) @(negedge clk);
    check(done == 0 && err == 0, "R1 reset flags", {done, err}, 0);
    check(skip_len == 0, "R1 reset skip_len", skip_len, 0);
    check(data_size == 0, "R1 reset data_size", data_size, 0);
    rst_n = 1'b1;

    for (int i = 0; i < NROWS; i++) begin
      build(ROWS[i], len, lastb);
      stream(len, -1);
      if (ROWS[i].xerr) begin
        check(err == 1'b1, "R2 R3 R6 R9 error row", err, 1);
        check(done_cnt == 0, "R6 R11 no done on error", done_cnt, 0);
      end else begin
        check(err == 1'b0, "R4 R5 no error", err, 0);
        check(skip_len == ROWS[i].bs, "R5 skip_len", skip_len, ROWS[i].bs);
        check(longint'(data_size) == exp_ds, "R7 R8 data_size", data_size, exp_ds);
        check(done_cnt == 1, "R8 done pulse count", done_cnt, 1);
        check(done_at == lastb, "R8 done timing", done_at, lastb);
      end
    end

    build(ROWS[0], len, lastb);
    stream(len, 24);
    check(err == 1'b1, "R9 gap over header length", err, 1);
    @(negedge clk);
    in_valid = 1'b1; in_idx = 0; in_byte = img[0];
    @(negedge clk);
    in_valid = 1'b0;
    check(err == 1'b0, "R10 restart clears err", err, 0);
    check(skip_len == 0 && data_size == 0, "R10 restart clears results", skip_len, 0);

    build(ROWS[1], len, lastb);
    stream(len, int'(ROWS[1].sz) + 2);
    check(err == 1'b1, "R9 gap inside size table", err, 1);
    check(done_cnt == 0, "R9 no done after gap", done_cnt, 0);

    build(ROWS[0], len, lastb);
    stream(len, -1);
    check(done_cnt == 1 && err == 0, "R8 rerun after error", done_cnt, 1);
    done_cnt = 0;
    for (int idx = len; idx < len + 20; idx++) begin
      @(negedge clk);
      if (done) done_cnt++;
      in_valid = 1'b1; in_idx = 32'(idx); in_byte = 8'(idx * 5 + 8);
    end
    @(negedge clk);
    in_valid = 1'b0;
    if (done) done_cnt++;
    @(negedge clk);
    check(done_cnt == 0, "R11 no done after completion", done_cnt, 0);
    check(longint'(data_size) == exp_ds, "R11 data_size held", data_size, exp_ds);
    check(skip_len == ROWS[0].bs, "R11 skip_len held", skip_len, ROWS[0].bs);
    check(err == 1'b0, "R11 no error after completion", err, 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule